// File: doc/BRIEF.md
# Checkpointed Register Alias Table

This block keeps one entry per architectural register. Each entry holds the tag of the newest in-flight instruction that will write that register, and a flag that says whether that value already exists. The decode stage reads two source registers from the table each cycle. It can also claim one destination register for a new tag. When a result is produced, a wakeup port broadcasts its tag. Every entry still waiting on that tag is then marked available.

For speculation past a branch, the table holds a second, backup copy of every entry. When a branch is decoded, the backup takes a snapshot of the current mapping, and only one such snapshot can be live at a time. A branch that arrives while a snapshot is live is refused and must stall.

Wakeups keep updating both copies, so the snapshot never holds stale flags. When the branch resolves correctly, the snapshot is dropped. When the branch was mispredicted, or an exception is reported on the same resolve port, the snapshot replaces the current copy in a single cycle. This discards every mapping made by instructions decoded after the branch.

Top module: `rename_map_ckpt`

## Requirements
- R1: After reset every entry reads tag 0 and ready=1, and no checkpoint is held (`ckpt_held`=0).
- R2: Each read port returns the current tag and ready flag of the addressed entry in the same cycle, without a clock edge. A destination claim made in the same cycle is not visible until the next cycle.
- R3: When `wk_valid` is high and the tag read on a port equals `wk_tag`, that port reports ready=1 in the same cycle.
- R4: A destination claim (`dec_valid`=1 and `dst_en`=1) makes the entry at `dst_idx` read `dst_tag` with ready=0 from the next cycle on. It does this unless a restore happens in the same cycle.
- R5: A wakeup sets ready=1, from the next cycle on, in every current entry whose tag equals `wk_tag`. A destination claim in the same cycle takes precedence for its own entry.
- R6: When `br_valid`=1 and no checkpoint is held, `br_accept`=1 in that cycle and `ckpt_held`=1 from the next cycle. The backup receives the current mapping including that cycle's claim and wakeup.
- R7: When `br_valid`=1 while a checkpoint is held, `br_stall`=1 and `br_accept`=0, and the held snapshot is left unchanged.
- R8: A resolve (`rsv_valid`=1) with `rsv_mispredict`=0 while a checkpoint is held clears `ckpt_held` on the next cycle and keeps the current mapping.
- R9: A resolve with `rsv_mispredict`=1 while a checkpoint is held makes the current mapping equal to the snapshot on the next cycle. This includes any wakeups the snapshot received while held. `ckpt_held` clears.
- R10: A restore and a destination claim in the same cycle: the restore wins and the claim is dropped.
- R11: A resolve while no checkpoint is held has no effect on the mapping or on `ckpt_held`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode slot valid |
| dst_en | input | 1 | Decode slot writes a destination |
| dst_idx | input | IDX_W | Destination architectural register |
| dst_tag | input | TAG_W | Tag of the new producer |
| rd0_idx | input | IDX_W | Source register for read port 0 |
| rd0_tag | output | TAG_W | Producer tag on port 0 |
| rd0_rdy | output | 1 | Value available on port 0 |
| rd1_idx | input | IDX_W | Source register for read port 1 |
| rd1_tag | output | TAG_W | Producer tag on port 1 |
| rd1_rdy | output | 1 | Value available on port 1 |
| wk_valid | input | 1 | Result broadcast valid |
| wk_tag | input | TAG_W | Tag of the completed result |
| br_valid | input | 1 | Branch in decode, requests a checkpoint |
| br_accept | output | 1 | Checkpoint taken this cycle |
| br_stall | output | 1 | Branch refused, a checkpoint is already held |
| rsv_valid | input | 1 | Branch resolve or exception report |
| rsv_mispredict | input | 1 | Resolve requests recovery to the checkpoint |
| ckpt_held | output | 1 | A checkpoint is live |

## Verification
Read ports, `br_accept` and `br_stall` are combinational. The bench therefore drives each cycle's inputs on the falling edge and samples them one time unit later, before the rising edge. Claims, wakeups, checkpoint capture and restore take effect at the next rising edge. They are checked one time unit after that edge, either through `ckpt_held` or through sweeps of both read ports over every entry with all controls idle. A reference model in the bench follows the same per-edge rules. A long pseudo-random stretch with periodic full sweeps covers the interactions of claims, wakeups, branches and resolves.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
  typedef enum logic {
    CK_IDLE = 1'b0,
    CK_HELD = 1'b1
  } ck_state_e;
endpackage

// File: rtl/rmap_entry.sv
module rmap_entry #(
  parameter int unsigned TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wk_valid,
  input  logic [TAG_W-1:0] wk_tag,
  input  logic             alloc_hit,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             take_ckpt,
  input  logic             restore,
  output logic [TAG_W-1:0] cur_tag,
  output logic             cur_rdy
);
  logic [TAG_W-1:0] bak_tag, cur_tag_n, bak_tag_n;
  logic             bak_rdy, cur_rdy_n, bak_rdy_n;
  logic             cur_wake, bak_wake;

  always_comb begin
    cur_wake = wk_valid && (wk_tag == cur_tag);
    bak_wake = wk_valid && (wk_tag == bak_tag);
    if (restore) begin
      cur_tag_n = bak_tag;
      cur_rdy_n = bak_rdy | bak_wake;
    end else if (alloc_hit) begin
      cur_tag_n = alloc_tag;
      cur_rdy_n = 1'b0;
    end else begin
      cur_tag_n = cur_tag;
      cur_rdy_n = cur_rdy | cur_wake;
    end
    if (take_ckpt) begin
      bak_tag_n = cur_tag_n;
      bak_rdy_n = cur_rdy_n;
    end else begin
      bak_tag_n = bak_tag;
      bak_rdy_n = bak_rdy | bak_wake;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_tag <= '0;
      cur_rdy <= 1'b1;
      bak_tag <= '0;
      bak_rdy <= 1'b1;
    end else begin
      cur_tag <= cur_tag_n;
      cur_rdy <= cur_rdy_n;
      bak_tag <= bak_tag_n;
      bak_rdy <= bak_rdy_n;
    end
  end
endmodule

// File: rtl/rmap_lookup.sv
module rmap_lookup #(
  parameter int unsigned NUM_ARCH = 8,
  parameter int unsigned TAG_W    = 4,
  localparam int unsigned IDX_W   = $clog2(NUM_ARCH)
) (
  input  logic [NUM_ARCH*TAG_W-1:0] tags_flat,
  input  logic [NUM_ARCH-1:0]       rdy_vec,
  input  logic [IDX_W-1:0]          idx,
  input  logic                      wk_valid,
  input  logic [TAG_W-1:0]          wk_tag,
  output logic [TAG_W-1:0]          tag,
  output logic                      rdy
);
  always_comb begin
    tag = tags_flat[idx*TAG_W +: TAG_W];
    rdy = rdy_vec[idx] | (wk_valid && (wk_tag == tag));
  end
endmodule

// File: rtl/rmap_ckpt_ctl.sv
module rmap_ckpt_ctl
  import rmap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic br_valid,
  input  logic rsv_valid,
  input  logic rsv_mispredict,
  output logic br_accept,
  output logic br_stall,
  output logic restore,
  output logic held
);
  ck_state_e st_q, st_n;

  always_comb begin
    held      = (st_q == CK_HELD);
    br_accept = br_valid && !held;
    br_stall  = br_valid && held;
    restore   = rsv_valid && rsv_mispredict && held;
    st_n      = st_q;
    if (br_accept)             st_n = CK_HELD;
    else if (rsv_valid && held) st_n = CK_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= CK_IDLE;
    else        st_q <= st_n;
  end
endmodule

// File: rtl/rename_map_ckpt.sv
module rename_map_ckpt #(
  parameter int unsigned NUM_ARCH = 8,
  parameter int unsigned TAG_W    = 4,
  localparam int unsigned IDX_W   = $clog2(NUM_ARCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic             dst_en,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic [TAG_W-1:0] dst_tag,
  input  logic [IDX_W-1:0] rd0_idx,
  output logic [TAG_W-1:0] rd0_tag,
  output logic             rd0_rdy,
  input  logic [IDX_W-1:0] rd1_idx,
  output logic [TAG_W-1:0] rd1_tag,
  output logic             rd1_rdy,
  input  logic             wk_valid,
  input  logic [TAG_W-1:0] wk_tag,
  input  logic             br_valid,
  output logic             br_accept,
  output logic             br_stall,
  input  logic             rsv_valid,
  input  logic             rsv_mispredict,
  output logic             ckpt_held
);
  logic [NUM_ARCH*TAG_W-1:0] tags_flat;
  logic [NUM_ARCH-1:0]       rdy_vec;
  logic                      restore;
  logic                      claim;

  assign claim = dec_valid && dst_en;

  rmap_ckpt_ctl ctl_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .br_valid       (br_valid),
    .rsv_valid      (rsv_valid),
    .rsv_mispredict (rsv_mispredict),
    .br_accept      (br_accept),
    .br_stall       (br_stall),
    .restore        (restore),
    .held           (ckpt_held)
  );

  for (genvar g = 0; g < NUM_ARCH; g++) begin : g_ent
    logic             hit;
    logic [TAG_W-1:0] e_tag;
    assign hit = claim && (dst_idx == IDX_W'(g));
    rmap_entry #(.TAG_W(TAG_W)) ent_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wk_valid  (wk_valid),
      .wk_tag    (wk_tag),
      .alloc_hit (hit),
      .alloc_tag (dst_tag),
      .take_ckpt (br_accept),
      .restore   (restore),
      .cur_tag   (e_tag),
      .cur_rdy   (rdy_vec[g])
    );
    assign tags_flat[g*TAG_W +: TAG_W] = e_tag;
  end

  rmap_lookup #(.NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W)) lk0_i (
    .tags_flat (tags_flat),
    .rdy_vec   (rdy_vec),
    .idx       (rd0_idx),
    .wk_valid  (wk_valid),
    .wk_tag    (wk_tag),
    .tag       (rd0_tag),
    .rdy       (rd0_rdy)
  );

  rmap_lookup #(.NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W)) lk1_i (
    .tags_flat (tags_flat),
    .rdy_vec   (rdy_vec),
    .idx       (rd1_idx),
    .wk_valid  (wk_valid),
    .wk_tag    (wk_tag),
    .tag       (rd1_tag),
    .rdy       (rd1_rdy)
  );
endmodule

// File: rtl/rename_map_ckpt_chk.sv
module rename_map_ckpt_chk #(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned TAG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dec_valid,
  input logic             dst_en,
  input logic [IDX_W-1:0] dst_idx,
  input logic [TAG_W-1:0] dst_tag,
  input logic [IDX_W-1:0] rd0_idx,
  input logic [TAG_W-1:0] rd0_tag,
  input logic             rd0_rdy,
  input logic             wk_valid,
  input logic [TAG_W-1:0] wk_tag,
  input logic             br_valid,
  input logic             br_accept,
  input logic             br_stall,
  input logic             rsv_valid,
  input logic             rsv_mispredict,
  input logic             ckpt_held
);
  // R3
  wake_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_valid && rd0_tag == wk_tag) |-> rd0_rdy);

  // R4
  claim_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dst_en && !(rsv_valid && rsv_mispredict && ckpt_held))
    |=> (rd0_idx != $past(dst_idx) || rd0_tag == $past(dst_tag)));

  // R6
  accept_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_accept |-> !ckpt_held);

  // R6
  accept_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_accept |=> ckpt_held);

  // R7
  second_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && ckpt_held) |-> (br_stall && !br_accept));

  // R8
  resolve_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_valid && ckpt_held) |=> !ckpt_held);

  // R11
  idle_resolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ckpt_held && !br_valid) |=> !ckpt_held);
endmodule

bind rename_map_ckpt rename_map_ckpt_chk #(.IDX_W(IDX_W), .TAG_W(TAG_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .dec_valid      (dec_valid),
  .dst_en         (dst_en),
  .dst_idx        (dst_idx),
  .dst_tag        (dst_tag),
  .rd0_idx        (rd0_idx),
  .rd0_tag        (rd0_tag),
  .rd0_rdy        (rd0_rdy),
  .wk_valid       (wk_valid),
  .wk_tag         (wk_tag),
  .br_valid       (br_valid),
  .br_accept      (br_accept),
  .br_stall       (br_stall),
  .rsv_valid      (rsv_valid),
  .rsv_mispredict (rsv_mispredict),
  .ckpt_held      (ckpt_held)
);

// File: tb/rename_map_ckpt_tb.sv
module rename_map_ckpt_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 8;
  localparam int TW = 4;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 0, dst_en = 0, wk_valid = 0, br_valid = 0;
  logic rsv_valid = 0, rsv_mispredict = 0;
  logic [IW-1:0] dst_idx = '0, rd0_idx = '0, rd1_idx = '0;
  logic [TW-1:0] dst_tag = '0, wk_tag = '0;
  logic [TW-1:0] rd0_tag, rd1_tag;
  logic rd0_rdy, rd1_rdy, br_accept, br_stall, ckpt_held;

  int n_run = 0;
  int n_fail = 0;

  int  m_tag [NA];
  bit  m_rdy [NA];
  int  b_tag [NA];
  bit  b_rdy [NA];
  bit  m_held;

  always #(CLK_PERIOD/2) clk = ~clk;

  rename_map_ckpt #(.NUM_ARCH(NA), .TAG_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dst_en(dst_en),
    .dst_idx(dst_idx), .dst_tag(dst_tag),
    .rd0_idx(rd0_idx), .rd0_tag(rd0_tag), .rd0_rdy(rd0_rdy),
    .rd1_idx(rd1_idx), .rd1_tag(rd1_tag), .rd1_rdy(rd1_rdy),
    .wk_valid(wk_valid), .wk_tag(wk_tag), .br_valid(br_valid),
    .br_accept(br_accept), .br_stall(br_stall), .rsv_valid(rsv_valid),
    .rsv_mispredict(rsv_mispredict), .ckpt_held(ckpt_held)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    dec_valid = 0; dst_en = 0; wk_valid = 0; br_valid = 0;
    rsv_valid = 0; rsv_mispredict = 0;
  endtask

  // Read every entry through both ports with all controls quiet.
  task automatic sweep(input string req);
    idle_inputs();
    for (int i = 0; i < NA; i++) begin
      rd0_idx = IW'(i);
      rd1_idx = IW'(NA - 1 - i);
      #1;
      chk(rd0_tag == TW'(m_tag[i]), {req, " tag p0"}, rd0_tag, m_tag[i]);
      chk(rd0_rdy == m_rdy[i], {req, " rdy p0"}, rd0_rdy, m_rdy[i]);
      chk(rd1_tag == TW'(m_tag[NA-1-i]), {req, " tag p1"}, rd1_tag, m_tag[NA-1-i]);
      chk(rd1_rdy == m_rdy[NA-1-i], {req, " rdy p1"}, rd1_rdy, m_rdy[NA-1-i]);
    end
  endtask

  // One clock cycle of stimulus with same-cycle and next-cycle checks.
  task automatic drive(input bit dv, input bit de, input int di, input int dt,
                       input bit wv, input int wt, input bit bv,
                       input bit rv, input bit rm, input int r0, input int r1);
    bit acc, rst_now, e0, e1;
    int nt [NA];
    bit nr [NA];
    @(negedge clk);
    dec_valid = dv; dst_en = de; dst_idx = IW'(di); dst_tag = TW'(dt);
    wk_valid = wv; wk_tag = TW'(wt); br_valid = bv;
    rsv_valid = rv; rsv_mispredict = rm;
    rd0_idx = IW'(r0); rd1_idx = IW'(r1);
    #1;
    e0 = m_rdy[r0] | (wv && m_tag[r0] == wt);
    e1 = m_rdy[r1] | (wv && m_tag[r1] == wt);
    // R2 lookup shows pre-write state, R3 forwards same-cycle wakeup
    chk(rd0_tag == TW'(m_tag[r0]), "R2 p0 tag", rd0_tag, m_tag[r0]);
    chk(rd1_tag == TW'(m_tag[r1]), "R2 p1 tag", rd1_tag, m_tag[r1]);
    chk(rd0_rdy == e0, "R3 p0 rdy", rd0_rdy, e0);
    chk(rd1_rdy == e1, "R3 p1 rdy", rd1_rdy, e1);
    acc = bv && !m_held;
    chk(br_accept == acc, "R6 br_accept", br_accept, acc);
    chk(br_stall == (bv && m_held), "R7 br_stall", br_stall, bv && m_held);
    rst_now = rv && rm && m_held;
    @(posedge clk);
    for (int i = 0; i < NA; i++) begin
      if (rst_now) begin
        nt[i] = b_tag[i];
        nr[i] = b_rdy[i] | (wv && b_tag[i] == wt);
      end else if (dv && de && i == di) begin
        nt[i] = dt;
        nr[i] = 1'b0;
      end else begin
        nt[i] = m_tag[i];
        nr[i] = m_rdy[i] | (wv && m_tag[i] == wt);
      end
      if (acc) begin
        b_tag[i] = nt[i];
        b_rdy[i] = nr[i];
      end else begin
        b_rdy[i] = b_rdy[i] | (wv && b_tag[i] == wt);
      end
      m_tag[i] = nt[i];
      m_rdy[i] = nr[i];
    end
    if (acc) m_held = 1'b1;
    else if (rv && m_held) m_held = 1'b0;
    #1;
    chk(ckpt_held == m_held, acc ? "R6 held" : (rv ? "R8 R11 held" : "R7 held"),
        ckpt_held, m_held);
    idle_inputs();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++;
    n_fail++;
    $display("[TB] FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int seed;
    for (int i = 0; i < NA; i++) begin
      m_tag[i] = 0; m_rdy[i] = 1; b_tag[i] = 0; b_rdy[i] = 1;
    end
    m_held = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    sweep("R1");
    chk(ckpt_held == 1'b0, "R1 held", ckpt_held, 0);

    // R4 claim every register, reading the same one in that cycle (R2)
    for (int i = 0; i < NA; i++)
      drive(1, 1, i, i + 1, 0, 0, 0, 0, 0, i, (i + 7) % NA);
    sweep("R4");

    // R5 wakeups on tags 1..4, port 0 reads the woken entry (R3)
    for (int t = 1; t <= 4; t++)
      drive(0, 0, 0, 0, 1, t, 0, 0, 0, t - 1, 7);
    sweep("R5");

    // R5 claim beats wakeup on the same entry
    drive(1, 1, 7, 13, 1, 8, 0, 0, 0, 7, 6);
    sweep("R5 claim priority");

    // R6 branch with a same-cycle claim, then R7 second branch
    drive(1, 1, 5, 9, 0, 0, 1, 0, 0, 5, 0);
    drive(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1);
    drive(1, 1, 6, 10, 0, 0, 0, 0, 0, 6, 0);
    drive(1, 1, 0, 11, 0, 0, 1, 0, 0, 0, 6);
    // wakeup of the older tag 7, only the snapshot still maps it
    drive(0, 0, 0, 0, 1, 7, 0, 0, 0, 6, 5);
    sweep("R7 speculative");
    // R9 mispredict with R10 simultaneous claim
    drive(1, 1, 1, 12, 1, 9, 0, 1, 1, 1, 5);
    sweep("R9 R10 restore");

    // R8 correct resolve keeps the speculative mapping
    drive(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1);
    drive(1, 1, 2, 14, 0, 0, 0, 0, 0, 2, 3);
    drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 2, 3);
    sweep("R8 keep");

    // R11 resolve with nothing held
    drive(1, 0, 3, 15, 0, 0, 0, 1, 1, 3, 2);
    sweep("R11 ignored");

    // pseudo-random stretch with periodic sweeps
    seed = 32'h1234_5678;
    for (int n = 0; n < 600; n++) begin
      int r;
      seed = seed * 1103515245 + 12345;
      r = seed >>> 8;
      drive(r[0], r[1], r[4:2], r[8:5], r[9], r[13:10],
            r[16:14] == 3'd0, r[19:17] == 3'd0, r[20],
            r[23:21], r[26:24]);
      if (n % 50 == 49) sweep("R9 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule